// File: doc/BRIEF.md
# Ethernet MAC Event Counter Bank with Wrap Flags

This block keeps one narrow event counter for each of fourteen receive and transmit conditions reported by an Ethernet MAC. The MAC datapaths raise a single-cycle strobe per event, and the matching counter advances by one. The counters are deliberately short, 12 or 16 bits. When one rolls over, it records the fact in a sticky wrap flag at a fixed bit of one of two flag words: one word for receive and one for transmit. Host software reads the counters, clears them, and adds a full counter span to its own wider copy for each flag it finds set. The host then clears the flags it has handled by writing ones to them.

Each flag word has a companion mask word. A flag raises the single interrupt line only while its mask bit is 0. After reset every mask bit is 1, so no interrupt can occur until software opens the bits it wants. A typical setup opens exactly the fourteen counter flags by writing 0xFFFFBE32 to the receive mask and 0xFFFE7E8B to the transmit mask.

Top module: `mac_stat_bank`

## Requirements
- R1: Reset (synchronous, active high) sets every counter to 0, both flag words to 0 and both mask words to 0xFFFFFFFF, and holds `irq` low.
- R2: A strobe on `rx_evt[i]` or `tx_evt[i]` that is high at a rising clock edge adds exactly 1 to that counter at that edge. Several strobes in one cycle each advance their own counter, and a counter with no strobe keeps its value.
- R3: Receive counter 5 (alignment errors) and all seven transmit counters are 12 bits wide. The other six receive counters are 16 bits wide. A strobe on a counter that holds all ones makes it read 0, and its wrap flag is set at that same edge.
- R4: Receive wrap flags in flag word 1 sit at these bits, by counter index: 0 drops at bit 0, 1 fragments at bit 2, 2 oversize at bit 3, 3 code errors at bit 6, 4 length errors at bit 7, 5 alignment errors at bit 8, 6 FCS errors at bit 14. Transmit wrap flags in flag word 2 sit at these bits: 0 total collisions at bit 2, 1 late collisions at bit 4, 2 multiple collisions at bit 5, 3 single collisions at bit 6, 4 deferred at bit 8, 5 undersize at bit 15, 6 oversize at bit 16.
- R5: A host write to a counter address sets that counter to 0 whatever the write data. If a strobe for the same counter occurs in the same cycle, the clear wins and the counter reads 0. Other counters are not touched.
- R6: A host write to a flag word clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R7: If a wrap and a host clear of the same flag occur in the same cycle, the flag ends set.
- R8: A flag stays set until the host clears it. Flag bits not listed in R4 always read 0, and writing to them has no effect.
- R9: A write to a mask address loads the full data word. `irq` is high exactly when some flag is set while its mask bit is 0, and it follows flag and mask changes without added delay.
- R10: Address map (`host_addr`): receive counter i at i (0 to 6), transmit counter i at 8+i (8 to 14), flag word 1 at 16, flag word 2 at 17, mask word 1 at 18, mask word 2 at 19. `host_rdata` shows the addressed register combinationally, counters zero-extended, and every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt | input | 7 | Receive event strobes, one per receive counter |
| tx_evt | input | 7 | Transmit event strobes, one per transmit counter |
| host_we | input | 1 | Host write enable, one write per cycle |
| host_addr | input | 5 | Host register address for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | High while any unmasked wrap flag is set |

## Verification
A counter whose value has gone wrong shows on its read address at the very next clock, but its wrap flag shows it only at the rollover, up to 65536 events later. The bench therefore drives a 12-bit counter and a 16-bit counter right up to the all-ones value. It confirms that the flag is still clear one event before the rollover and set at the rollover itself. An error in a flag position or in the clear logic appears in the flag word and on `irq` in the cycle after the wrap or the host write. The bench also sets up the two same-cycle conflicts on purpose: a counter clear against a strobe, and a flag clear against a wrap.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int NUM_RX   = 7;
    localparam int NUM_TX   = 7;
    localparam int FIELD_W  = 5;
    localparam int FLAG_MAX = 64;

    typedef enum logic [1:0] {
        GRP_RX   = 2'd0,
        GRP_TX   = 2'd1,
        GRP_REG  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        REG_FLAG1 = 2'd0,
        REG_FLAG2 = 2'd1,
        REG_MASK1 = 2'd2,
        REG_MASK2 = 2'd3
    } reg_e;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] idx;
    } target_t;

    // Flag bit of each receive counter (R4)
    function automatic int rx_flag_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 2;
            2:       return 3;
            3:       return 6;
            4:       return 7;
            5:       return 8;
            default: return 14;
        endcase
    endfunction

    // Flag bit of each transmit counter (R4)
    function automatic int tx_flag_pos(input int i);
        case (i)
            0:       return 2;
            1:       return 4;
            2:       return 5;
            3:       return 6;
            4:       return 8;
            5:       return 15;
            default: return 16;
        endcase
    endfunction

    // Only the alignment counter on the receive side is short (R3)
    function automatic bit rx_is_short(input int i);
        return (i == 5);
    endfunction

    function automatic logic [FLAG_MAX-1:0] rx_legal_bits();
        logic [FLAG_MAX-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_RX; i++) m[rx_flag_pos(i)] = 1'b1;
        return m;
    endfunction

    function automatic logic [FLAG_MAX-1:0] tx_legal_bits();
        logic [FLAG_MAX-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_TX; i++) m[tx_flag_pos(i)] = 1'b1;
        return m;
    endfunction

    // Address field split: [4:3] group, [2:0] index (R10)
    function automatic target_t decode(input logic [FIELD_W-1:0] a, input logic hi_zero);
        target_t t;
        t.idx = a[2:0];
        t.grp = GRP_NONE;
        if (hi_zero) begin
            case (a[4:3])
                2'd0: t.grp = (a[2:0] == 3'd7) ? GRP_NONE : GRP_RX;
                2'd1: t.grp = (a[2:0] == 3'd7) ? GRP_NONE : GRP_TX;
                2'd2: t.grp = a[2] ? GRP_NONE : GRP_REG;
                default: t.grp = GRP_NONE;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/mstat_counter.sv
module mstat_counter #(
    parameter int W     = 12,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             clr,
    output logic             wrap,
    output logic [REG_W-1:0] value
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (evt)  cnt <= cnt + 1'b1;
    end

    assign wrap  = evt && !clr && (cnt == ALL_ONES);
    assign value = REG_W'(cnt);

    // R2: one step per strobe below the top
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (evt && !clr && cnt != ALL_ONES) |=> (cnt == W'($past(cnt) + 1'b1)));

    // R2: no strobe, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr) |=> $stable(cnt));

    // R3: rollover lands on zero
    a_r3_rollover: assert property (@(posedge clk) disable iff (rst)
        (evt && cnt == ALL_ONES) |=> (cnt == '0));

    // R5: host clear wins
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/mstat_flags.sv
module mstat_flags #(
    parameter int               REG_W = 32,
    parameter logic [REG_W-1:0] LEGAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic             mask_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] flags,
    output logic [REG_W-1:0] mask,
    output logic             pending
);
    logic [REG_W-1:0] clr_vec;

    assign clr_vec = clr_en ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '1;
        end else begin
            flags <= ((flags & ~clr_vec) | set_vec) & LEGAL;
            if (mask_we) mask <= wdata;
        end
    end

    assign pending = |(flags & ~mask);

    // R7: a wrap always leaves its flag set, even against a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R6: written ones clear unless a wrap hits the same bit
    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((flags & $past(wdata) & ~$past(set_vec)) == '0));

    // R8: a flag only falls through a host clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~flags & $past(flags) & ~$past(clr_vec)) == '0));

    // R8: bits without a counter stay zero
    a_r8_legal: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~LEGAL) == '0));

endmodule

// File: rtl/mstat_hostif.sv
module mstat_hostif
    import mstat_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int REG_W  = 32,
    parameter int N_RX   = NUM_RX,
    parameter int N_TX   = NUM_TX
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_we,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [N_RX-1:0][REG_W-1:0] rx_val,
    input  logic [N_TX-1:0][REG_W-1:0] tx_val,
    input  logic [REG_W-1:0]           flag1,
    input  logic [REG_W-1:0]           flag2,
    input  logic [REG_W-1:0]           mask1,
    input  logic [REG_W-1:0]           mask2,
    output logic [N_RX-1:0]            rx_clr,
    output logic [N_TX-1:0]            tx_clr,
    output logic                       flag1_clr,
    output logic                       flag2_clr,
    output logic                       mask1_we,
    output logic                       mask2_we,
    output logic [REG_W-1:0]           rdata
);
    target_t tgt;
    logic    hi_zero;

    assign hi_zero = ((host_addr >> FIELD_W) == '0);
    assign tgt     = decode(FIELD_W'(host_addr), hi_zero);

    // write strobes
    always_comb begin
        rx_clr    = '0;
        tx_clr    = '0;
        flag1_clr = 1'b0;
        flag2_clr = 1'b0;
        mask1_we  = 1'b0;
        mask2_we  = 1'b0;
        if (host_we) begin
            case (tgt.grp)
                GRP_RX: rx_clr[tgt.idx] = 1'b1;
                GRP_TX: tx_clr[tgt.idx] = 1'b1;
                GRP_REG: begin
                    case (reg_e'(tgt.idx[1:0]))
                        REG_FLAG1: flag1_clr = 1'b1;
                        REG_FLAG2: flag2_clr = 1'b1;
                        REG_MASK1: mask1_we  = 1'b1;
                        default:   mask2_we  = 1'b1;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        case (tgt.grp)
            GRP_RX: rdata = rx_val[tgt.idx];
            GRP_TX: rdata = tx_val[tgt.idx];
            GRP_REG: begin
                case (reg_e'(tgt.idx[1:0]))
                    REG_FLAG1: rdata = flag1;
                    REG_FLAG2: rdata = flag2;
                    REG_MASK1: rdata = mask1;
                    default:   rdata = mask2;
                endcase
            end
            default: rdata = '0;
        endcase
    end

    // R10: a write reaches at most one target and only when enabled
    a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_clr, tx_clr, flag1_clr, flag2_clr, mask1_we, mask2_we}));

    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !host_we |-> ({rx_clr, tx_clr, flag1_clr, flag2_clr, mask1_we, mask2_we} == '0));

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mstat_pkg::*;
#(
    parameter int SHORT_W = 12,
    parameter int LONG_W  = 16,
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_RX-1:0] rx_evt,
    input  logic [NUM_TX-1:0] tx_evt,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              irq
);
    localparam logic [FLAG_MAX-1:0] RX_ALL = rx_legal_bits();
    localparam logic [FLAG_MAX-1:0] TX_ALL = tx_legal_bits();
    localparam logic [REG_W-1:0]    RX_LEGAL = RX_ALL[REG_W-1:0];
    localparam logic [REG_W-1:0]    TX_LEGAL = TX_ALL[REG_W-1:0];

    logic [NUM_RX-1:0]            rx_clr, rx_wrap;
    logic [NUM_TX-1:0]            tx_clr, tx_wrap;
    logic [NUM_RX-1:0][REG_W-1:0] rx_val;
    logic [NUM_TX-1:0][REG_W-1:0] tx_val;
    logic [REG_W-1:0]             set1, set2;
    logic [REG_W-1:0]             flag1, flag2, mask1, mask2;
    logic                         flag1_clr, flag2_clr, mask1_we, mask2_we;
    logic                         pend1, pend2;

    for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
        localparam int CW = rx_is_short(i) ? SHORT_W : LONG_W;
        mstat_counter #(.W(CW), .REG_W(REG_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .evt   (rx_evt[i]),
            .clr   (rx_clr[i]),
            .wrap  (rx_wrap[i]),
            .value (rx_val[i])
        );
    end

    for (genvar i = 0; i < NUM_TX; i++) begin : g_tx
        mstat_counter #(.W(SHORT_W), .REG_W(REG_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .evt   (tx_evt[i]),
            .clr   (tx_clr[i]),
            .wrap  (tx_wrap[i]),
            .value (tx_val[i])
        );
    end

    // Route each wrap to its fixed flag bit
    always_comb begin
        set1 = '0;
        set2 = '0;
        for (int i = 0; i < NUM_RX; i++) set1[rx_flag_pos(i)] = set1[rx_flag_pos(i)] | rx_wrap[i];
        for (int i = 0; i < NUM_TX; i++) set2[tx_flag_pos(i)] = set2[tx_flag_pos(i)] | tx_wrap[i];
    end

    mstat_flags #(.REG_W(REG_W), .LEGAL(RX_LEGAL)) u_flag1 (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set1),
        .clr_en  (flag1_clr),
        .mask_we (mask1_we),
        .wdata   (host_wdata),
        .flags   (flag1),
        .mask    (mask1),
        .pending (pend1)
    );

    mstat_flags #(.REG_W(REG_W), .LEGAL(TX_LEGAL)) u_flag2 (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set2),
        .clr_en  (flag2_clr),
        .mask_we (mask2_we),
        .wdata   (host_wdata),
        .flags   (flag2),
        .mask    (mask2),
        .pending (pend2)
    );

    mstat_hostif #(.ADDR_W(ADDR_W), .REG_W(REG_W), .N_RX(NUM_RX), .N_TX(NUM_TX)) u_host (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_addr (host_addr),
        .rx_val    (rx_val),
        .tx_val    (tx_val),
        .flag1     (flag1),
        .flag2     (flag2),
        .mask1     (mask1),
        .mask2     (mask2),
        .rx_clr    (rx_clr),
        .tx_clr    (tx_clr),
        .flag1_clr (flag1_clr),
        .flag2_clr (flag2_clr),
        .mask1_we  (mask1_we),
        .mask2_we  (mask2_we),
        .rdata     (host_rdata)
    );

    assign irq = pend1 | pend2;

    // R9: no flags, no interrupt
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (flag1 == '0 && flag2 == '0) |-> !irq);

    // R9: everything masked, no interrupt
    a_r9_masked: assert property (@(posedge clk) disable iff (rst)
        (&mask1 && &mask2) |-> !irq);

    // R3: a wrap strobe reaches its flag word at the next edge
    a_r3_flag_follows: assert property (@(posedge clk) disable iff (rst)
        (|rx_wrap) |=> (flag1 != '0));

endmodule

// File: tb/mac_stat_bank_test.sv
module mac_stat_bank_test;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [6:0]        rx_evt = '0;
    logic [6:0]        tx_evt = '0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [REG_W-1:0]  host_wdata = '0;
    logic [REG_W-1:0]  host_rdata;
    logic              irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mac_stat_bank uut (
        .clk        (clk),
        .rst        (rst),
        .rx_evt     (rx_evt),
        .tx_evt     (tx_evt),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq        (irq)
    );

    typedef enum logic [1:0] { OP_EVT, OP_WR, OP_RD } op_e;
    typedef struct packed {
        op_e         op;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // data of OP_EVT: [6:0] receive strobes, [13:7] transmit strobes
    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{OP_RD,  5'd16, 32'h0,        32'h0,        4'd1},  // R1 flag word 1
        '{OP_RD,  5'd18, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask word 1
        '{OP_RD,  5'd0,  32'h0,        32'h0,        4'd1},  // R1 counter
        '{OP_EVT, 5'd0,  32'h0003,     32'h0,        4'd2},
        '{OP_EVT, 5'd0,  32'h0001,     32'h0,        4'd2},
        '{OP_RD,  5'd0,  32'h0,        32'd2,        4'd2},  // R2 two strobes
        '{OP_RD,  5'd1,  32'h0,        32'd1,        4'd2},  // R2 one strobe
        '{OP_RD,  5'd2,  32'h0,        32'd0,        4'd2},  // R2 untouched
        '{OP_EVT, 5'd0,  32'h0400,     32'h0,        4'd2},  // tx 3
        '{OP_RD,  5'd11, 32'h0,        32'd1,        4'd10}, // R10 tx 3 at 11
        '{OP_WR,  5'd0,  32'h1234,     32'h0,        4'd5},
        '{OP_RD,  5'd0,  32'h0,        32'd0,        4'd5},  // R5 cleared
        '{OP_RD,  5'd1,  32'h0,        32'd1,        4'd5},  // R5 neighbour kept
        '{OP_WR,  5'd18, 32'hFFFFBE32, 32'h0,        4'd9},
        '{OP_RD,  5'd18, 32'h0,        32'hFFFFBE32, 4'd9},  // R9 mask load
        '{OP_WR,  5'd17, 32'h00000001, 32'h0,        4'd8},
        '{OP_RD,  5'd17, 32'h0,        32'h0,        4'd8},  // R8 no set by write
        '{OP_RD,  5'd7,  32'h0,        32'h0,        4'd10}, // R10 hole
        '{OP_RD,  5'd24, 32'h0,        32'h0,        4'd10}, // R10 unmapped
        '{OP_RD,  5'd19, 32'h0,        32'hFFFFFFFF, 4'd10}  // R10 mask word 2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        @(negedge clk);
        #1;
        check(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic host_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic strobe(input logic [6:0] rx, input logic [6:0] tx, input int n);
        @(negedge clk);
        rx_evt = rx; tx_evt = tx;
        repeat (n) @(negedge clk);
        rx_evt = '0; tx_evt = '0;
    endtask

    task automatic strobe_and_write(input logic [6:0] rx, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        rx_evt = rx; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        rx_evt = '0; host_we = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=200000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 irq after reset
        irq_chk("R1 irq low", 1'b0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            case (TBL[k].op)
                OP_EVT: strobe(TBL[k].data[6:0], TBL[k].data[13:7], 1);
                OP_WR:  host_write(TBL[k].addr, TBL[k].data);
                default: read_chk($sformatf("R%0d vec%0d", TBL[k].req, k), TBL[k].addr, TBL[k].exp);
            endcase
        end

        // R5: clear against a same-cycle strobe on counter 1
        strobe_and_write(7'b0000010, 5'd1, 32'hFFFFFFFF);
        read_chk("R5 clear wins", 5'd1, 32'd0);

        // R3/R4: 12-bit alignment counter reaches top without a flag
        strobe(7'b0100000, 7'd0, 4095);
        read_chk("R3 align at top", 5'd5, 32'hFFF);
        read_chk("R3 no flag before wrap", 5'd16, 32'h0);
        strobe(7'b0100000, 7'd0, 1);
        read_chk("R3 align wrapped", 5'd5, 32'h0);
        read_chk("R4 align flag bit 8", 5'd16, 32'h100);
        irq_chk("R9 unmasked flag raises irq", 1'b1);

        // R6: write-one-to-clear, zero bits ignored
        host_write(5'd16, 32'h0);
        read_chk("R6 zero write keeps flag", 5'd16, 32'h100);
        host_write(5'd16, 32'h100);
        read_chk("R6 flag cleared", 5'd16, 32'h0);
        irq_chk("R9 irq drops", 1'b0);

        // R7: wrap against same-cycle clear
        strobe(7'b0100000, 7'd0, 4095);
        strobe_and_write(7'b0100000, 5'd16, 32'h100);
        read_chk("R7 flag survives clear", 5'd16, 32'h100);
        read_chk("R8 flag still set", 5'd16, 32'h100);
        host_write(5'd16, 32'hFFFFFFFF);

        // R3/R4: all transmit counters wrap together, masked
        strobe(7'd0, 7'h7F, 4096);
        read_chk("R4 tx flag bits", 5'd17, 32'h00018174);
        read_chk("R3 tx counter 6 wrapped", 5'd14, 32'h0);
        read_chk("R3 tx counter 3 wrapped", 5'd11, 32'h1);
        irq_chk("R9 masked tx flags", 1'b0);
        host_write(5'd19, 32'hFFFE7E8B);
        irq_chk("R9 unmask tx", 1'b1);
        host_write(5'd19, 32'hFFFFFFFF);
        irq_chk("R9 remask tx", 1'b0);

        // R3/R4: 16-bit receive counters
        strobe(7'h7F, 7'd0, 65535);
        read_chk("R3 drop at top", 5'd0, 32'hFFFF);
        read_chk("R3 fcs at top", 5'd6, 32'hFFFF);
        read_chk("R4 only align before wrap", 5'd16, 32'h100);
        strobe(7'h7F, 7'd0, 1);
        read_chk("R3 drop wrapped", 5'd0, 32'h0);
        read_chk("R4 rx flag bits", 5'd16, 32'h000041CD);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_chk("R1 flags cleared", 5'd17, 32'h0);
        read_chk("R1 counter cleared", 5'd6, 32'h0);
        read_chk("R1 mask restored", 5'd18, 32'hFFFFFFFF);
        irq_chk("R1 irq low after reset", 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule